// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox between a host processor and a management microcontroller. The host stages up to four 32-bit payload words in an outbound buffer, then writes a command word that carries a command code, a 4-bit sub-command, a payload size and a request for an interrupt on completion. Writing the command latches it, marks the mailbox busy and raises a pending-command level toward the controller. The controller reads the latched word and the outbound buffer by word index, leaves results in an inbound buffer, and ends the command with a one-cycle completion strobe that carries an error flag and a 7-bit error code.

The host either polls the busy flag in the status register or waits for the completion interrupt, a one-cycle pulse that fires only when the command asked for it. The pulse also sets a sticky pending flag in status, which the host clears by writing 1 to that bit. A command written while the mailbox is busy is discarded and leaves a sticky overrun mark in the top bit of the status error code, so the latched command is never disturbed. Host reads are registered: read data appears one cycle after the read strobe, and is zero in every cycle without one.

Address decode (byte offsets from the block base): command at 0x00, status at 0x04, outbound buffer at 0x80–0x8F, inbound buffer at 0x90–0x9F.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, busy, error, error code and the pending flag are 0, the status register reads only the initiator id in bits 15:8, and neither host_irq nor ctl_cmd_pending is high.
- R2: A host write to offset 0x00 while idle latches the full 32-bit word onto ctl_cmd_word and sets busy and ctl_cmd_pending from the next cycle; the command word holds the code in bits 7:0, the interrupt request in bit 8, the sub-command in bits 15:12 and the size in bits 23:16.
- R3: The status word is {8'h00, error code[7:0], INIT_ID[7:0], sub-command[3:0], 1'b0, pending, error, busy}, the sub-command being the one of the latched command.
- R4: A completion strobe while busy clears busy and loads the error flag and the low 7 error-code bits from the controller in the same edge.
- R5: A completion of a command with bit 8 set produces a one-cycle host_irq pulse in the cycle after the strobe and sets status bit 2; a completion without bit 8 does neither.
- R6: A host write to offset 0x04 with bit 2 set clears the pending flag; writes with bit 2 clear change no status field.
- R7: A command write while busy is dropped (latched word unchanged) and sets error-code bit 7, which stays set through completion until the next accepted command.
- R8: Accepting a command clears the error flag and the whole error code.
- R9: Host word stores at 0x80 + 4*i are read by the controller at index i; host reads of 0x00 and of 0x80–0x8F return zero.
- R10: Controller writes at index i appear at host offset 0x90 + 4*i; a word read returns the whole word, a byte read returns byte addr[1:0] (little-endian lane) zero-extended.
- R11: A completion strobe while idle changes no status field and raises no host_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_byte | input | 1 | Read is a single-byte load |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| host_irq | output | 1 | One-cycle completion interrupt to the host |
| ctl_cmd_pending | output | 1 | Command waiting for the controller (equals busy) |
| ctl_cmd_word | output | 32 | Latched command word |
| ctl_wbuf_idx | input | $clog2(BUF_WORDS) | Outbound buffer word index |
| ctl_wbuf_data | output | 32 | Outbound buffer word at ctl_wbuf_idx |
| ctl_rbuf_we | input | 1 | Inbound buffer write enable |
| ctl_rbuf_idx | input | $clog2(BUF_WORDS) | Inbound buffer word index |
| ctl_rbuf_wdata | input | 32 | Inbound buffer write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_done_err | input | 1 | Completion error flag |
| ctl_done_code | input | 7 | Completion error code |

## Verification
The bench builds the block with its defaults, BUF_WORDS = 4 and INIT_ID = 8'h5A, which keeps both buffers at four words so every word index and every one of the sixteen inbound byte lanes is read back. It sweeps all sixteen sub-commands against both settings of the interrupt request, so each completion path, the pulse, the pending flag and its clear are reached with varied error values. Overrun, idle completion and the clear of a stale error by the next command are driven as separate sequences.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_WBUF = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_RBUF = 8'h90;
  localparam int CMD_IOC_BIT  = 8;
  localparam int CMD_SUB_LSB  = 12;
  localparam int STAT_PEND_BIT = 2;

  function automatic logic [DATA_W-1:0] pack_status(
    input logic [7:0] code, input logic [7:0] id, input logic [3:0] sub,
    input logic pend, input logic err, input logic busy);
    return {8'h00, code, id, sub, 1'b0, pend, err, busy};
  endfunction
endpackage

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g))) words[g] <= wr_data;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              pend_clr,
  input  logic              done,
  input  logic              done_err,
  input  logic [6:0]        done_code,
  output logic [DATA_W-1:0] cmd_q,
  output logic              busy,
  output logic              err,
  output logic [7:0]        code,
  output logic              pend,
  output logic              host_irq
);
  logic       ovr_q;
  logic [6:0] code_q;
  logic       accept, drop, finish, notify;

  assign accept = cmd_wr & ~busy;
  assign drop   = cmd_wr & busy;
  assign finish = done & busy;
  assign notify = finish & cmd_q[CMD_IOC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy   <= 1'b0;
      err    <= 1'b0;
      ovr_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (accept) begin
        cmd_q  <= cmd_wdata;
        busy   <= 1'b1;
        err    <= 1'b0;
        ovr_q  <= 1'b0;
        code_q <= '0;
      end
      if (drop) ovr_q <= 1'b1;
      if (finish) begin
        busy   <= 1'b0;
        err    <= done_err;
        code_q <= done_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      host_irq <= notify;
      if (notify) pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
    end
  end

  assign code = {ovr_q, code_q};

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));
  // R7
  drop_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code[7] && !(cmd_wr && !busy)) |=> code[7]);
  // R4
  finish_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  // R5
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
  // R5
  irq_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> pend);
  // R11
  idle_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done && !cmd_wr) |=> ($stable(err) && $stable(code) && !host_irq));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int          BUF_WORDS = 4,
  parameter logic [7:0]  INIT_ID   = 8'h5A,
  localparam int IW      = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int BOFS_W  = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_byte,
  input  logic [7:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_irq,
  output logic              ctl_cmd_pending,
  output logic [31:0]       ctl_cmd_word,
  input  logic [IW-1:0]     ctl_wbuf_idx,
  output logic [31:0]       ctl_wbuf_data,
  input  logic              ctl_rbuf_we,
  input  logic [IW-1:0]     ctl_rbuf_idx,
  input  logic [31:0]       ctl_rbuf_wdata,
  input  logic              ctl_done,
  input  logic              ctl_done_err,
  input  logic [6:0]        ctl_done_code
);
  logic            is_cmd, is_stat, in_wbuf, in_rbuf;
  logic [IW-1:0]   host_idx;
  logic [1:0]      lane;
  logic            busy, err, pend;
  logic [7:0]      code;
  logic [31:0]     rbuf_word, status, rmux;

  assign is_cmd   = (host_addr == OFS_CMD);
  assign is_stat  = (host_addr == OFS_STAT);
  assign in_wbuf  = (host_addr[7:BOFS_W] == OFS_WBUF[7:BOFS_W]);
  assign in_rbuf  = (host_addr[7:BOFS_W] == OFS_RBUF[7:BOFS_W]);
  assign host_idx = host_addr[BOFS_W-1:2];
  assign lane     = host_addr[1:0];

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (host_wr & is_cmd),
    .cmd_wdata (host_wdata),
    .pend_clr  (host_wr & is_stat & host_wdata[STAT_PEND_BIT]),
    .done      (ctl_done),
    .done_err  (ctl_done_err),
    .done_code (ctl_done_code),
    .cmd_q     (ctl_cmd_word),
    .busy      (busy),
    .err       (err),
    .code      (code),
    .pend      (pend),
    .host_irq  (host_irq)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(32)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr & in_wbuf),
    .wr_idx  (host_idx),
    .wr_data (host_wdata),
    .rd_idx  (ctl_wbuf_idx),
    .rd_data (ctl_wbuf_data)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(32)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_rbuf_we),
    .wr_idx  (ctl_rbuf_idx),
    .wr_data (ctl_rbuf_wdata),
    .rd_idx  (host_idx),
    .rd_data (rbuf_word)
  );

  assign ctl_cmd_pending = busy;
  assign status = pack_status(code, INIT_ID, ctl_cmd_word[CMD_SUB_LSB +: 4], pend, err, busy);

  always_comb begin
    rmux = '0;
    if (is_stat) rmux = status;
    else if (in_rbuf) begin
      if (host_byte) rmux = {24'h0, rbuf_word[8*lane +: 8]};
      else           rmux = rbuf_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rmux;
    else              host_rdata <= '0;
  end
endmodule

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
  localparam logic [7:0] ID = 8'h5A;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, host_byte = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_irq, ctl_cmd_pending;
  logic [31:0] ctl_cmd_word, ctl_wbuf_data;
  logic [1:0] ctl_wbuf_idx = 0, ctl_rbuf_idx = 0;
  logic ctl_rbuf_we = 0;
  logic [31:0] ctl_rbuf_wdata = 0;
  logic ctl_done = 0, ctl_done_err = 0;
  logic [6:0] ctl_done_code = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmd_mailbox dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input logic [7:0] code, input logic [3:0] sub,
                                     input logic pend, input logic err, input logic busy);
    return {8'h00, code, ID, sub, 1'b0, pend, err, busy};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; host_byte = b;
    @(negedge clk); d = host_rdata; host_rd = 0; host_byte = 0;
  endtask

  task automatic finish_cmd(input logic e, input logic [6:0] c,
                            output logic irq_now, output logic irq_next);
    @(negedge clk); ctl_done = 1; ctl_done_err = e; ctl_done_code = c;
    @(negedge clk); irq_now = host_irq; ctl_done = 0;
    @(negedge clk); irq_next = host_irq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic i1, i2;
    logic [3:0] last_sub;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h04, 0, d); chk("R1 status", d, st(8'h00, 4'h0, 0, 0, 0));
    chk("R1 irq", {30'h0, host_irq, ctl_cmd_pending}, 32'h0);

    // R9 outbound buffer sweep
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4 * i), 32'hA5000000 + 32'(i * 32'h01010101));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ctl_wbuf_idx = 2'(i); #1;
      chk("R9 ctl view", ctl_wbuf_data, 32'hA5000000 + 32'(i * 32'h01010101));
      rd(8'h80 + 8'(4 * i), 0, d); chk("R9 host read zero", d, 32'h0);
    end
    rd(8'h00, 0, d); chk("R9 cmd read zero", d, 32'h0);

    // R2 R3 R4 R5 R6 R8 sweep over sub-command and interrupt request
    last_sub = 0;
    for (int s = 0; s < 16; s++) begin
      for (int q = 0; q < 2; q++) begin
        logic [31:0] cw;
        logic e;
        logic [6:0] c;
        cw = {8'h00, 8'(s + 4), 4'(s), 3'b000, 1'(q), 8'(8'h10 + s)};
        e = 1'((s + q) & 1);
        c = 7'((s * 9 + q * 5) & 7'h7f);
        wr(8'h00, cw);
        chk("R2 cmd word", ctl_cmd_word, cw);
        chk("R2 pending", {31'h0, ctl_cmd_pending}, 32'h1);
        rd(8'h04, 0, d); chk("R3 R8 busy status", d, st(8'h00, 4'(s), 0, 0, 1));
        finish_cmd(e, c, i1, i2);
        chk("R5 irq pulse", {31'h0, i1}, 32'(q));
        chk("R5 irq one cycle", {31'h0, i2}, 32'h0);
        rd(8'h04, 0, d); chk("R4 R5 done status", d, st({1'b0, c}, 4'(s), 1'(q), e, 0));
        wr(8'h04, 32'hFFFF_FFFB);
        rd(8'h04, 0, d); chk("R6 no-clear write", d, st({1'b0, c}, 4'(s), 1'(q), e, 0));
        wr(8'h04, 32'h0000_0004);
        rd(8'h04, 0, d); chk("R6 clear pend", d, st({1'b0, c}, 4'(s), 0, e, 0));
        last_sub = 4'(s);
      end
    end

    // R11 completion while idle
    finish_cmd(1, 7'h33, i1, i2);
    chk("R11 no irq", {30'h0, i1, i2}, 32'h0);
    rd(8'h04, 0, d); chk("R11 status unchanged", d, st({1'b0, 7'((15 * 9 + 5) & 7'h7f)}, last_sub, 0, 0, 0));

    // R7 overrun
    wr(8'h00, 32'h0003_7142);
    wr(8'h00, 32'h0009_2199);
    chk("R7 latched kept", ctl_cmd_word, 32'h0003_7142);
    rd(8'h04, 0, d); chk("R7 overrun mark", d, st(8'h80, 4'h7, 0, 0, 1));
    finish_cmd(1, 7'h12, i1, i2);
    chk("R7 irq", {31'h0, i1}, 32'h1);
    rd(8'h04, 0, d); chk("R7 sticky through done", d, st(8'h92, 4'h7, 1, 1, 0));
    wr(8'h00, 32'h0000_3001);
    rd(8'h04, 0, d); chk("R8 R7 cleared on accept", d, st(8'h00, 4'h3, 1, 0, 1));
    finish_cmd(0, 7'h00, i1, i2);
    chk("R5 no irq without request", {31'h0, i1}, 32'h0);
    wr(8'h04, 32'h4);

    // R10 inbound buffer
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ctl_rbuf_we = 1; ctl_rbuf_idx = 2'(i);
      ctl_rbuf_wdata = 32'h11223344 ^ 32'(i * 32'h10203040);
    end
    @(negedge clk); ctl_rbuf_we = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h11223344 ^ 32'(i * 32'h10203040);
      rd(8'h90 + 8'(4 * i), 0, d); chk("R10 word read", d, w);
      for (int b = 0; b < 4; b++) begin
        rd(8'h90 + 8'(4 * i + b), 1, d);
        chk("R10 byte read", d, {24'h0, w[8*b +: 8]});
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule